// File: doc/BRIEF.md
# Interrupt Group Line Signaller

This block looks at a small bank of interrupt sources and, every clock cycle, finds the one that should be taken next. Each source has a pending bit, an enable bit, a priority value and a group code: group 0, secure group 1 or non-secure group 1. Three per-group enables and a priority mask decide which sources may compete. The smallest priority value wins.

The block then picks the request line for the winner. That choice depends on the winner's group, the processor's current exception level and its current security state. Group 0 always uses the fast line (FIQ). At the top exception level, every group uses the fast line. Below that level, a group 1 interrupt uses the normal line (IRQ) when it belongs to the security state the processor is running in, and the fast line when it belongs to the other state.

Source `i` has the interrupt ID `ID_BASE + i`. IDs 1020 to 1023 are reserved and never reach the output. ID 1023 on the output means that nothing is being signalled (spurious).

Top module: `irq_line_signaller`

## Requirements
- R1: Among the eligible sources, the one with the numerically smallest priority value is selected. When two sources have the same priority value, the one with the lower interrupt ID wins.
- R2: A source is eligible only if its pending bit is 1, its enable bit is 1 and the enable of its group is 1. Group codes are 2'b00 for group 0, 2'b01 for secure group 1 and 2'b10 for non-secure group 1. A source with group code 2'b11 is never eligible.
- R3: The selected source is signalled only if its priority value is strictly less than `prio_mask`. A mask of 0 blocks every source.
- R4: A signalled group 0 interrupt always drives `fiq_o` and never `irq_o`.
- R5: When `cur_el` equals 3, every signalled interrupt drives `fiq_o`, whatever its group and whatever `cur_ns` is.
- R6: When `cur_el` is 0, 1 or 2, a group 1 interrupt drives `irq_o` if its security matches the current state, and `fiq_o` otherwise. `cur_ns`=1 means the processor is in non-secure state; secure group 1 matches `cur_ns`=0 and non-secure group 1 matches `cur_ns`=1.
- R7: When no interrupt is signalled, both lines are low and `sel_id_o` is 1023.
- R8: Source `i` has the ID `ID_BASE + i`. A source whose ID falls in 1020 to 1023 is never selected.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and they are evaluated again on every edge. Acknowledging the winner (clearing its pending bit) or changing a group enable therefore takes effect one cycle later.
- R10: While `rst_n` is low, a clock edge sets `fiq_o` and `irq_o` low and `sel_id_o` to 1023.
- R11: `fiq_o` and `irq_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pending | input | NUM_SRC | Pending bit of each source |
| src_enable | input | NUM_SRC | Enable bit of each source |
| src_prio | input | NUM_SRC*PRIO_W | Priority value of each source; source i uses bits [i*PRIO_W +: PRIO_W] |
| src_group | input | NUM_SRC*2 | Group code of each source; source i uses bits [i*2 +: 2] |
| grp0_en | input | 1 | Enable for group 0 |
| grp1s_en | input | 1 | Enable for secure group 1 |
| grp1ns_en | input | 1 | Enable for non-secure group 1 |
| prio_mask | input | PRIO_W | Priority mask; a source needs a value strictly below it |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| cur_ns | input | 1 | Current security state: 1 = non-secure, 0 = secure |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| sel_id_o | output | ID_W | ID of the signalled interrupt, or 1023 when nothing is signalled |

## Verification
The bench builds two copies of the block, both with eight sources and 8-bit priorities. The first copy uses `ID_BASE`=0, so its IDs fall in the software-generated range; it covers priority ties, the mask boundary, group code 2'b11 and the full table of group, exception level and security state. The second copy uses `ID_BASE`=1014, so sources 6 and 7 land on the reserved IDs 1020 and 1021. This is the only way to check that reserved IDs are never selected, even when those sources have the best priority.

// File: rtl/isl_pkg.sv
// Package: shared group encoding and fixed ID values for the line signaller.
// Assumes: IDs are at least 10 bits wide, so that 1023 can be represented.
package isl_pkg;
    typedef enum logic [1:0] {
        GRP_G0   = 2'b00,
        GRP_G1S  = 2'b01,
        GRP_G1NS = 2'b10,
        GRP_RSVD = 2'b11
    } grp_e;

    localparam int unsigned SPURIOUS_ID      = 1023;
    localparam int unsigned FIRST_SPECIAL_ID = 1020;
    localparam logic [1:0]  TOP_EL           = 2'd3;
endpackage

// File: rtl/isl_eligibility.sv
// Module: isl_eligibility
// Decides, for each source, whether it may compete for selection. A source
// competes when it is pending, enabled, in an enabled group and has a valid
// group code. Sources whose fixed ID is reserved are tied off.
// Assumes: source i has ID ID_BASE + i.
module isl_eligibility
    import isl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ID_BASE = 0
) (
    input  logic [NUM_SRC-1:0]   pending,
    input  logic [NUM_SRC-1:0]   enable,
    input  logic [NUM_SRC*2-1:0] group,
    input  logic                 g0_en,
    input  logic                 g1s_en,
    input  logic                 g1ns_en,
    output logic [NUM_SRC-1:0]   elig
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int unsigned SRC_ID = ID_BASE + g;
        if (SRC_ID < FIRST_SPECIAL_ID) begin : g_valid
            logic grp_on;
            // Look up the enable that belongs to this source's group.
            always_comb begin
                unique case (grp_e'(group[g*2 +: 2]))
                    GRP_G0:   grp_on = g0_en;
                    GRP_G1S:  grp_on = g1s_en;
                    GRP_G1NS: grp_on = g1ns_en;
                    default:  grp_on = 1'b0;
                endcase
            end
            assign elig[g] = pending[g] & enable[g] & grp_on;
        end else begin : g_reserved
            assign elig[g] = 1'b0;
        end
    end
endmodule

// File: rtl/isl_arbiter.sv
// Module: isl_arbiter
// Finds the eligible source with the smallest priority value. On equal
// values the lower index wins, because only a strictly smaller value
// replaces the current best.
// Assumes: a small NUM_SRC, so a linear scan meets timing.
module isl_arbiter #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRIO_W  = 8,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Scan from index 0 upwards and keep the strictly best source.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found || prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/isl_line_router.sv
// Module: isl_line_router
// Applies the priority mask to the winner, then chooses the fast or the
// normal request line from the winner's group, the exception level and
// the security state.
// Assumes: cur_ns = 1 means non-secure state; level 3 is the top level.
module isl_line_router
    import isl_pkg::*;
#(
    parameter int unsigned PRIO_W = 8
) (
    input  logic              found,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic [1:0]        win_grp,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [1:0]        cur_el,
    input  logic              cur_ns,
    output logic              want_fiq,
    output logic              want_irq
);
    logic go;
    logic use_fiq;

    // The winner needs a priority value strictly below the mask.
    assign go = found && (win_prio < prio_mask);

    // Pick the line: group 0, the top level or the other security state use FIQ.
    always_comb begin
        if (cur_el == TOP_EL) begin
            use_fiq = 1'b1;
        end else begin
            unique case (grp_e'(win_grp))
                GRP_G0:   use_fiq = 1'b1;
                GRP_G1S:  use_fiq = cur_ns;
                GRP_G1NS: use_fiq = !cur_ns;
                default:  use_fiq = 1'b1;
            endcase
        end
    end

    assign want_fiq = go && use_fiq;
    assign want_irq = go && !use_fiq;
endmodule

// File: rtl/irq_line_signaller.sv
// Module: irq_line_signaller (top)
// Every cycle it selects the best pending source and registers the request
// line and the selected ID. When nothing qualifies, both lines are low and
// the ID is the spurious value.
// Assumes: ID_BASE + NUM_SRC - 1 fits in ID_W bits.
module irq_line_signaller
    import isl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned ID_W    = 10,
    parameter int unsigned ID_BASE = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC-1:0]        src_enable,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC*2-1:0]      src_group,
    input  logic                      grp0_en,
    input  logic                      grp1s_en,
    input  logic                      grp1ns_en,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [1:0]                cur_el,
    input  logic                      cur_ns,
    output logic                      fiq_o,
    output logic                      irq_o,
    output logic [ID_W-1:0]           sel_id_o
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

    logic [NUM_SRC-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic [1:0]         win_grp;
    logic               want_fiq;
    logic               want_irq;

    isl_eligibility #(.NUM_SRC(NUM_SRC), .ID_BASE(ID_BASE)) u_elig (
        .pending (src_pending),
        .enable  (src_enable),
        .group   (src_group),
        .g0_en   (grp0_en),
        .g1s_en  (grp1s_en),
        .g1ns_en (grp1ns_en),
        .elig    (elig)
    );

    isl_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .elig     (elig),
        .prio     (src_prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    // Take the group code of the winning source.
    assign win_grp = src_group[win_idx*2 +: 2];

    isl_line_router #(.PRIO_W(PRIO_W)) u_route (
        .found     (found),
        .win_prio  (win_prio),
        .win_grp   (win_grp),
        .prio_mask (prio_mask),
        .cur_el    (cur_el),
        .cur_ns    (cur_ns),
        .want_fiq  (want_fiq),
        .want_irq  (want_irq)
    );

    // Register the request lines and the ID; recomputed on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_o    <= 1'b0;
            irq_o    <= 1'b0;
            sel_id_o <= SPUR;
        end else begin
            fiq_o    <= want_fiq;
            irq_o    <= want_irq;
            sel_id_o <= (want_fiq || want_irq)
                        ? ID_W'(ID_BASE) + ID_W'(win_idx) : SPUR;
        end
    end
endmodule

// File: rtl/isl_checker.sv
// Module: isl_checker
// Holds the properties of irq_line_signaller. It is bound to every instance
// of the top module.
module isl_checker
    import isl_pkg::*;
#(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned ID_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grp1s_en,
    input logic              grp1ns_en,
    input logic [PRIO_W-1:0] prio_mask,
    input logic [1:0]        cur_el,
    input logic              fiq_o,
    input logic              irq_o,
    input logic [ID_W-1:0]   sel_id_o
);
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fiq_o, irq_o})); // R11
    AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiq_o && !irq_o) |-> (sel_id_o == ID_W'(SPURIOUS_ID))); // R7
    AST_NO_SPECIAL_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o || irq_o) |-> (sel_id_o < ID_W'(FIRST_SPECIAL_ID))); // R8
    AST_TOP_EL_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == TOP_EL) |=> !irq_o); // R5
    AST_G0_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp1s_en && !grp1ns_en) |=> !irq_o); // R4
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_mask == '0) |=> (!fiq_o && !irq_o)); // R3
endmodule

bind irq_line_signaller isl_checker #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_isl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp1s_en  (grp1s_en),
    .grp1ns_en (grp1ns_en),
    .prio_mask (prio_mask),
    .cur_el    (cur_el),
    .fiq_o     (fiq_o),
    .irq_o     (irq_o),
    .sel_id_o  (sel_id_o)
);

// File: tb/test_irq_line_signaller.sv
`timescale 1ns/1ps
module test_irq_line_signaller;
    localparam int N = 8;
    localparam int PW = 8;
    localparam int IW = 10;
    localparam int BASE_HI = 1014;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pend = '0, en = '0;
    logic [N*PW-1:0] prio = '0;
    logic [N*2-1:0] grp = '0;
    logic g0en = 1'b0, g1sen = 1'b0, g1nsen = 1'b0;
    logic [PW-1:0] mask = '0;
    logic [1:0] el = 2'd1;
    logic ns = 1'b1;
    logic fiq_a, irq_a, fiq_b, irq_b;
    logic [IW-1:0] id_a, id_b;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_line_signaller #(.NUM_SRC(N), .PRIO_W(PW), .ID_W(IW), .ID_BASE(0)) i_irq_line_signaller (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_enable(en),
        .src_prio(prio), .src_group(grp), .grp0_en(g0en), .grp1s_en(g1sen),
        .grp1ns_en(g1nsen), .prio_mask(mask), .cur_el(el), .cur_ns(ns),
        .fiq_o(fiq_a), .irq_o(irq_a), .sel_id_o(id_a));

    irq_line_signaller #(.NUM_SRC(N), .PRIO_W(PW), .ID_W(IW), .ID_BASE(BASE_HI)) i_irq_line_signaller_hi (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_enable(en),
        .src_prio(prio), .src_group(grp), .grp0_en(g0en), .grp1s_en(g1sen),
        .grp1ns_en(g1nsen), .prio_mask(mask), .cur_el(el), .cur_ns(ns),
        .fiq_o(fiq_b), .irq_o(irq_b), .sel_id_o(id_b));

    // Expected outputs, computed from the requirements.
    function automatic void model(input int base, output logic ef, output logic ei, output int eid);
        int best = -1;
        int bp = 0;
        ef = 0; ei = 0; eid = 1023;
        for (int i = 0; i < N; i++) begin
            logic [1:0] gc = grp[i*2 +: 2];
            logic gon = (gc == 2'b00) ? g0en : (gc == 2'b01) ? g1sen : (gc == 2'b10) ? g1nsen : 1'b0;
            int p = int'(prio[i*PW +: PW]);
            if (pend[i] && en[i] && gon && (base + i) < 1020 && (best < 0 || p < bp)) begin
                best = i; bp = p;
            end
        end
        if (best >= 0 && bp < int'(mask)) begin
            logic [1:0] gc = grp[best*2 +: 2];
            logic f;
            if (el == 2'd3 || gc == 2'b00) f = 1;
            else if (gc == 2'b01) f = ns;
            else f = !ns;
            ef = f; ei = !f; eid = base + best;
        end
    endfunction

    task automatic compare(input string req, input logic af, input logic ai, input logic [IW-1:0] aid,
                           input logic ef, input logic ei, input int eid);
        checks++;
        if (af !== ef || ai !== ei || int'(aid) != eid) begin
            failures++;
            $display("FAIL %s: got fiq=%b irq=%b id=%0d, expected fiq=%b irq=%b id=%0d",
                     req, af, ai, aid, ef, ei, eid);
        end
    endtask

    // Let one edge capture the inputs, then compare both instances with the model.
    task automatic step(input string req);
        logic ef, ei;
        int eid;
        @(posedge clk); #1;
        model(0, ef, ei, eid);
        compare(req, fiq_a, irq_a, id_a, ef, ei, eid);
        model(BASE_HI, ef, ei, eid);
        compare({req, " hi"}, fiq_b, irq_b, id_b, ef, ei, eid);
    endtask

    task automatic set_src(input int i, input logic p, input logic e, input logic [PW-1:0] pr, input logic [1:0] g);
        pend[i] = p; en[i] = e; prio[i*PW +: PW] = pr; grp[i*2 +: 2] = g;
    endtask

    task automatic clear_all();
        pend = '0; en = '0; prio = '1; grp = '0;
        g0en = 1; g1sen = 1; g1nsen = 1; mask = 8'hFF; el = 2'd1; ns = 1;
    endtask

    initial begin
        // R10: reset state
        @(posedge clk); #1;
        compare("R10 reset", fiq_a, irq_a, id_a, 0, 0, 1023);
        compare("R10 reset hi", fiq_b, irq_b, id_b, 0, 0, 1023);
        @(negedge clk); rst_n = 1;
        clear_all();
        step("R7 nothing pending");

        // R1: equal priority, the lower ID wins
        set_src(2, 1, 1, 8'h40, 2'b10); set_src(5, 1, 1, 8'h40, 2'b10);
        step("R1 tie lowest id");
        set_src(5, 1, 1, 8'h3F, 2'b10);
        step("R1 smaller value wins");
        // R9: acknowledging the winner hands over to the next source
        pend[5] = 0;
        step("R9 ack reselects");
        // R3: a mask equal to the priority blocks the source
        mask = 8'h40;
        step("R3 mask equal blocks");
        mask = 8'h41;
        step("R3 mask above passes");
        // R2: group code 3 and a cleared group enable both exclude a source
        clear_all();
        set_src(1, 1, 1, 8'h10, 2'b11); set_src(4, 1, 1, 8'h80, 2'b01);
        step("R2 reserved group skipped");
        g1sen = 0;
        step("R2 group enable off");
        // R4: group 0 in non-secure EL1
        clear_all();
        set_src(3, 1, 1, 8'h20, 2'b00);
        step("R4 group0 fiq");
        // R6: group 1 in both security states
        set_src(3, 1, 1, 8'h20, 2'b10);
        step("R6 ns g1 in ns irq");
        ns = 0;
        step("R6 ns g1 in secure fiq");
        set_src(3, 1, 1, 8'h20, 2'b01);
        step("R6 s g1 in secure irq");
        ns = 1;
        step("R6 s g1 in ns fiq");
        // R5: every group uses FIQ at the top level
        el = 2'd3; ns = 0;
        step("R5 el3 fiq");
        // R8: reserved IDs are skipped in the high instance
        clear_all();
        set_src(6, 1, 1, 8'h00, 2'b10); set_src(7, 1, 1, 8'h00, 2'b00);
        step("R8 only reserved ids");
        set_src(0, 1, 1, 8'hF0, 2'b00);
        step("R8 reserved best prio skipped");

        // R1 R2 R3 R4 R5 R6 R7 R11: random stimulus
        void'($urandom(32'd1357));
        for (int k = 0; k < 400; k++) begin
            pend = N'($urandom); en = N'($urandom);
            for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'($urandom_range(0, 15) * 16);
            grp = (2*N)'($urandom);
            g0en = 1'($urandom); g1sen = 1'($urandom); g1nsen = 1'($urandom);
            mask = PW'($urandom); el = 2'($urandom); ns = 1'($urandom);
            step("R1 R11 random");
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got no end, expected end of test");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule